// File: doc/BRIEF.md
# Serial Instruction Receiver with Even Parity and Error Lock

This block is the command front end of a serially accessed memory-style slave. While chip select is high, the host clocks in bits one at a time. The block samples a data bit on every clock cycle in which the serial clock enable is high. Each frame carries one instruction: an 8-bit opcode, then a 16-bit address for the commands that need one, then one optional parity bit. The parity bit is expected only when the parity-enable pin is high. When a frame is complete and correct, the block emits a one-cycle command strobe that carries the opcode and the address. This strobe feeds the memory controller, which sits outside this block.

There are two kinds of error: an opcode the block does not recognise, and a parity mismatch. Either one records a flag and locks the block. While locked, the block ignores the data input, issues no strobes and keeps the data output released. The lock is cleared only by taking chip select low and then high again. That same select cycle does not clear the flags. The next status read reports them, and the next error-free instruction clears them.

Two commands return data on the serial output: the status read and the pointer read. The status byte starts with the fixed pattern 101, so the host can tell a live device, busy or not, from a locked one whose output floats. The busy state is an input supplied from outside the block, and so is the pointer value.

Top module: `scmd_frontend`

## Requirements
- R1: After reset, the output enable and the command strobe are both low.
- R2: Every received bit, address bits included, is taken MSB first. Sequential read is opcode 0xCB with a 16-bit address, and write-at-address is 0x52 with a 16-bit address. Erase-all is 0x92, status read is 0xC5 and pointer read is 0xC6, and these three take no address. On the clock edge that samples the last bit, `cmdValid` rises for exactly one cycle, with the opcode and the address (zero for commands without an address).
- R3: When `parityEn` is high, one further bit follows the frame. The XOR of every bit in the frame, parity bit included, must be 0 (even parity).
- R4: A parity mismatch produces no strobe, sets the parity-error flag and locks the block.
- R5: An opcode outside the R2 list sets the instruction-error flag and locks the block on its 8th bit.
- R6: While locked, the block ignores the data input: no strobe is issued and `doutOe` stays low.
- R7: The lock is cleared only by chip select going low and then high. The flags survive this, are reported by the next status read, and are cleared by any error-free instruction.
- R8: The status word is sent MSB first. Bits 7..5 read 101, bit 4 is parity error, bit 3 is instruction error, bit 2 is busy (`busyIn` at completion), and bits 1..0 read 0.
- R9: When an instruction completes, `doutOe` rises only for status read and pointer read. Pointer read sends `ptrIn` MSB first, 16 bits. The output then advances one bit per sampled clock. `doutOe` falls in the cycle after chip select is seen low.
- R10: Chip select going low in the middle of a frame abandons it, with no error and no strobe.
- R11: Once an instruction has completed, further bits in the same frame are ignored until chip select rises again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| csIn | input | 1 | Chip select, high while a frame is active |
| sclkEn | input | 1 | Serial clock enable, samples one bit per high cycle |
| dataIn | input | 1 | Serial data input |
| parityEn | input | 1 | High: a trailing even-parity bit is expected |
| busyIn | input | 1 | Program/erase cycle in progress |
| ptrIn | input | 16 | Pointer value returned by pointer read |
| doutVal | output | 1 | Serial data output value |
| doutOe | output | 1 | Output drive enable, low means high impedance |
| cmdValid | output | 1 | One-cycle strobe for a completed instruction |
| cmdOpcode | output | 8 | Opcode of the completed instruction |
| cmdAddr | output | 16 | Address of the completed instruction |

## Verification
The assertions assume that chip select, the serial enable and the parity-enable pin change only between clock edges. They also assume that `parityEn` is held steady throughout a frame, and that a bit is never clocked in the same cycle that chip select rises. The bench drives every input on the falling clock edge. It changes `parityEn` only while chip select is low, and it waits one full cycle after raising chip select before sending the first bit.

// File: rtl/scmd_pkg.sv
package scmd_pkg;

  localparam int OP_W   = 8;
  localparam int STAT_W = 8;

  localparam logic [OP_W-1:0] OP_SEQREAD  = 8'hCB;
  localparam logic [OP_W-1:0] OP_WRITEAT  = 8'h52;
  localparam logic [OP_W-1:0] OP_ERASEALL = 8'h92;
  localparam logic [OP_W-1:0] OP_STATUS   = 8'hC5;
  localparam logic [OP_W-1:0] OP_PTRREAD  = 8'hC6;

  typedef enum logic [1:0] {
    ST_RECV = 2'd0,
    ST_DONE = 2'd1,
    ST_LOCK = 2'd2
  } ctrlState_t;

  typedef struct packed {
    logic known;
    logic hasAddr;
    logic isStatus;
    logic isPtr;
  } opInfo_t;

  // strobes from the control FSM to the datapath
  typedef struct packed {
    logic clrFrame;
    logic accBit;
    logic shiftIn;
    logic capture;
    logic loadStatus;
    logic loadPtr;
    logic shiftOut;
    logic setParErr;
    logic setInsErr;
    logic clrFlags;
  } strobe_t;

  function automatic opInfo_t decodeOp(input logic [OP_W-1:0] op);
    opInfo_t info;
    info = '0;
    case (op)
      OP_SEQREAD:  begin info.known = 1'b1; info.hasAddr = 1'b1; end
      OP_WRITEAT:  begin info.known = 1'b1; info.hasAddr = 1'b1; end
      OP_ERASEALL: begin info.known = 1'b1; end
      OP_STATUS:   begin info.known = 1'b1; info.isStatus = 1'b1; end
      OP_PTRREAD:  begin info.known = 1'b1; info.isPtr = 1'b1; end
      default:     info = '0;
    endcase
    return info;
  endfunction

endpackage

// File: rtl/scmd_ctrl.sv
module scmd_ctrl
  import scmd_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int CNT_W  = 5
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             csIn,
  input  logic             sclkEn,
  input  logic             dataIn,
  input  logic             parityEn,
  input  logic [CNT_W-1:0] bitCnt,
  input  logic             parAcc,
  input  logic [OP_W-1:0]  incomingOp,
  output strobe_t          strb,
  output logic             hasAddr,
  output logic             lockedNow
);

  ctrlState_t state, nextState;
  logic       csPrev;
  logic       csRise;
  logic       sample;
  opInfo_t    infoReg;
  opInfo_t    curInfo;
  logic [CNT_W-1:0] newCnt;
  logic [CNT_W-1:0] totalBits;
  logic       lastBit;
  logic       opBit;

  assign csRise = csIn & ~csPrev;
  assign sample = csIn & csPrev & sclkEn;
  assign newCnt = bitCnt + CNT_W'(1);
  assign opBit  = (newCnt == CNT_W'(OP_W));

  // the opcode is decoded from the incoming bit on the 8th sample
  assign curInfo = opBit ? decodeOp(incomingOp) : infoReg;

  assign totalBits = CNT_W'(OP_W)
                   + (curInfo.hasAddr ? CNT_W'(ADDR_W) : CNT_W'(0))
                   + CNT_W'(parityEn);
  assign lastBit   = (newCnt == totalBits);
  assign hasAddr   = curInfo.hasAddr;
  assign lockedNow = (state == ST_LOCK);

  always_comb begin
    strb      = '0;
    nextState = state;
    if (!csIn) begin
      strb.clrFrame = 1'b1;
      if (state != ST_LOCK) nextState = ST_RECV;
    end else if (csRise) begin
      nextState = ST_RECV;
    end else if (sample) begin
      case (state)
        ST_RECV: begin
          strb.accBit  = 1'b1;
          strb.shiftIn = !(parityEn && lastBit);
          if (opBit && !curInfo.known) begin
            strb.setInsErr = 1'b1;
            nextState      = ST_LOCK;
          end else if (lastBit) begin
            if (parityEn && (parAcc ^ dataIn)) begin
              strb.setParErr = 1'b1;
              nextState      = ST_LOCK;
            end else begin
              strb.capture    = 1'b1;
              strb.clrFlags   = 1'b1;
              strb.loadStatus = curInfo.isStatus;
              strb.loadPtr    = curInfo.isPtr;
              nextState       = ST_DONE;
            end
          end
        end
        ST_DONE: strb.shiftOut = 1'b1;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state   <= ST_RECV;
      csPrev  <= 1'b0;
      infoReg <= '0;
    end else begin
      state  <= nextState;
      csPrev <= csIn;
      if (state == ST_RECV && sample && opBit) infoReg <= curInfo;
    end
  end

endmodule

// File: rtl/scmd_datapath.sv
module scmd_datapath
  import scmd_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int CNT_W  = 5
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           strb,
  input  logic              dataIn,
  input  logic              busyIn,
  input  logic              hasAddr,
  input  logic [ADDR_W-1:0] ptrIn,
  output logic [CNT_W-1:0]  bitCnt,
  output logic              parAcc,
  output logic [OP_W-1:0]   incomingOp,
  output logic              doutVal,
  output logic              doutOe,
  output logic              cmdValid,
  output logic [OP_W-1:0]   cmdOpcode,
  output logic [ADDR_W-1:0] cmdAddr
);

  localparam int FRAME_W = OP_W + ADDR_W;
  localparam int OUT_W   = ADDR_W;

  logic [FRAME_W-1:0] frameReg;
  logic [FRAME_W-1:0] nextFrame;
  logic [OUT_W-1:0]   outReg;
  logic               parErr;
  logic               insErr;
  logic [STAT_W-1:0]  statusWord;

  assign nextFrame  = strb.shiftIn ? {frameReg[FRAME_W-2:0], dataIn} : frameReg;
  assign incomingOp = {frameReg[OP_W-2:0], dataIn};
  assign statusWord = {3'b101, parErr, insErr, busyIn, 2'b00};
  assign doutVal    = outReg[OUT_W-1];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      bitCnt    <= '0;
      parAcc    <= 1'b0;
      frameReg  <= '0;
      outReg    <= '0;
      doutOe    <= 1'b0;
      cmdValid  <= 1'b0;
      cmdOpcode <= '0;
      cmdAddr   <= '0;
      parErr    <= 1'b0;
      insErr    <= 1'b0;
    end else begin
      cmdValid <= strb.capture;
      if (strb.clrFrame) begin
        bitCnt   <= '0;
        parAcc   <= 1'b0;
        frameReg <= '0;
        doutOe   <= 1'b0;
      end else begin
        if (strb.accBit) begin
          bitCnt <= bitCnt + CNT_W'(1);
          parAcc <= parAcc ^ dataIn;
        end
        frameReg <= nextFrame;
      end
      if (strb.capture) begin
        cmdOpcode <= hasAddr ? nextFrame[FRAME_W-1 -: OP_W] : nextFrame[OP_W-1:0];
        cmdAddr   <= hasAddr ? nextFrame[ADDR_W-1:0] : '0;
      end
      if (strb.loadStatus) begin
        outReg <= {statusWord, {(OUT_W-STAT_W){1'b0}}};
        doutOe <= 1'b1;
      end else if (strb.loadPtr) begin
        outReg <= ptrIn;
        doutOe <= 1'b1;
      end else if (strb.shiftOut) begin
        outReg <= {outReg[OUT_W-2:0], 1'b0};
      end
      if (strb.setParErr)     parErr <= 1'b1;
      else if (strb.clrFlags) parErr <= 1'b0;
      if (strb.setInsErr)     insErr <= 1'b1;
      else if (strb.clrFlags) insErr <= 1'b0;
    end
  end

endmodule

// File: rtl/scmd_frontend.sv
module scmd_frontend
  import scmd_pkg::*;
#(
  parameter int ADDR_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              csIn,
  input  logic              sclkEn,
  input  logic              dataIn,
  input  logic              parityEn,
  input  logic              busyIn,
  input  logic [ADDR_W-1:0] ptrIn,
  output logic              doutVal,
  output logic              doutOe,
  output logic              cmdValid,
  output logic [OP_W-1:0]   cmdOpcode,
  output logic [ADDR_W-1:0] cmdAddr
);

  localparam int CNT_W = $clog2(OP_W + ADDR_W + 2);

  strobe_t          strb;
  logic [CNT_W-1:0] bitCnt;
  logic             parAcc;
  logic [OP_W-1:0]  incomingOp;
  logic             hasAddr;
  logic             lockedNow;

  scmd_ctrl #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .csIn       (csIn),
    .sclkEn     (sclkEn),
    .dataIn     (dataIn),
    .parityEn   (parityEn),
    .bitCnt     (bitCnt),
    .parAcc     (parAcc),
    .incomingOp (incomingOp),
    .strb       (strb),
    .hasAddr    (hasAddr),
    .lockedNow  (lockedNow)
  );

  scmd_datapath #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) dpath (
    .clk        (clk),
    .rstN       (rstN),
    .strb       (strb),
    .dataIn     (dataIn),
    .busyIn     (busyIn),
    .hasAddr    (hasAddr),
    .ptrIn      (ptrIn),
    .bitCnt     (bitCnt),
    .parAcc     (parAcc),
    .incomingOp (incomingOp),
    .doutVal    (doutVal),
    .doutOe     (doutOe),
    .cmdValid   (cmdValid),
    .cmdOpcode  (cmdOpcode),
    .cmdAddr    (cmdAddr)
  );

endmodule

// File: rtl/scmd_frontend_chk.sv
module scmd_frontend_chk
  import scmd_pkg::*;
(
  input logic            clk,
  input logic            rstN,
  input logic            csIn,
  input logic            doutVal,
  input logic            doutOe,
  input logic            cmdValid,
  input logic [OP_W-1:0] cmdOpcode,
  input logic            lockedNow
);

  assert_strobe_single_R2: assert property (@(posedge clk) disable iff (!rstN)
    cmdValid |=> !cmdValid);

  assert_locked_quiet_R6: assert property (@(posedge clk) disable iff (!rstN)
    lockedNow |-> (!doutOe && !cmdValid));

  assert_status_prefix_R8: assert property (@(posedge clk) disable iff (!rstN)
    (cmdValid && cmdOpcode == OP_STATUS) |-> (doutOe && doutVal));

  assert_oe_only_reads_R9: assert property (@(posedge clk) disable iff (!rstN)
    $rose(doutOe) |-> (cmdValid && (cmdOpcode == OP_STATUS || cmdOpcode == OP_PTRREAD)));

  assert_oe_release_R9: assert property (@(posedge clk) disable iff (!rstN)
    !csIn |=> !doutOe);

endmodule

bind scmd_frontend scmd_frontend_chk chk (
  .clk       (clk),
  .rstN      (rstN),
  .csIn      (csIn),
  .doutVal   (doutVal),
  .doutOe    (doutOe),
  .cmdValid  (cmdValid),
  .cmdOpcode (cmdOpcode),
  .lockedNow (lockedNow)
);

// File: tb/scmd_frontend_test.sv
module scmd_frontend_test;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        csIn = 1'b0;
  logic        sclkEn = 1'b0;
  logic        dataIn = 1'b0;
  logic        parityEn = 1'b0;
  logic        busyIn = 1'b0;
  logic [15:0] ptrIn = 16'h0000;
  logic        doutVal;
  logic        doutOe;
  logic        cmdValid;
  logic [7:0]  cmdOpcode;
  logic [15:0] cmdAddr;

  int total = 0;
  int bad = 0;
  bit summaryDone = 0;

  always #10 clk = ~clk;

  scmd_frontend uut (
    .clk(clk), .rstN(rstN), .csIn(csIn), .sclkEn(sclkEn), .dataIn(dataIn),
    .parityEn(parityEn), .busyIn(busyIn), .ptrIn(ptrIn), .doutVal(doutVal),
    .doutOe(doutOe), .cmdValid(cmdValid), .cmdOpcode(cmdOpcode), .cmdAddr(cmdAddr)
  );

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic finishRun();
    if (!summaryDone) begin
      summaryDone = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  task automatic startFrame();
    @(negedge clk) csIn = 1'b0;
    repeat (2) @(negedge clk);
    csIn = 1'b1;
    @(negedge clk);
  endtask

  task automatic sendBit(input logic b);
    @(negedge clk) begin dataIn = b; sclkEn = 1'b1; end
    @(negedge clk) sclkEn = 1'b0;
  endtask

  task automatic sendBits(input logic [31:0] v, input int n);
    for (int i = n - 1; i >= 0; i--) sendBit(v[i]);
  endtask

  // opcode, optional address, and parity bit when parityEn is high
  task automatic sendCmd(input logic [7:0] op, input logic [15:0] addr, input bit withAddr, input bit badPar);
    logic p;
    sendBits({24'd0, op}, 8);
    p = ^op;
    if (withAddr) begin
      sendBits({16'd0, addr}, 16);
      p = p ^ (^addr);
    end
    if (parityEn) sendBit(p ^ badPar);
  endtask

  task automatic readBits(input int n, output logic [15:0] v);
    v = '0;
    for (int i = 0; i < n; i++) begin
      v = {v[14:0], doutVal};
      sendBit(1'b0);
    end
  endtask

  task automatic t_reset();
    check(doutOe == 1'b0, "R1 oe", doutOe, 0);
    check(cmdValid == 1'b0, "R1 valid", cmdValid, 0);
  endtask

  task automatic t_seqRead(input bit pe);
    @(negedge clk) parityEn = pe;
    startFrame();
    sendCmd(8'hCB, 16'h3A5C, 1, 0);
    check(cmdValid == 1'b1, pe ? "R3 valid with parity" : "R2 valid", cmdValid, 1);
    check(cmdOpcode == 8'hCB, "R2 opcode", cmdOpcode, 8'hCB);
    check(cmdAddr == 16'h3A5C, "R2 address", cmdAddr, 16'h3A5C);
    check(doutOe == 1'b0, "R9 hi-z after seq read", doutOe, 0);
    @(negedge clk);
    check(cmdValid == 1'b0, "R2 single pulse", cmdValid, 0);
  endtask

  task automatic t_writeAt();
    @(negedge clk) parityEn = 1'b1;
    startFrame();
    sendCmd(8'h52, 16'h8001, 1, 0);
    check(cmdValid && cmdOpcode == 8'h52 && cmdAddr == 16'h8001, "R3 write-at parity ok",
          {cmdOpcode, cmdAddr}, {8'h52, 16'h8001});
  endtask

  task automatic readStatus(output logic [15:0] v);
    startFrame();
    sendCmd(8'hC5, 16'h0, 0, 0);
    check(cmdValid == 1'b1, "R7 status accepted", cmdValid, 1);
    check(doutOe == 1'b1, "R9 status drives", doutOe, 1);
    readBits(8, v);
  endtask

  task automatic t_parityErr();
    logic [15:0] v;
    @(negedge clk) parityEn = 1'b1;
    startFrame();
    sendCmd(8'hCB, 16'h1234, 1, 1);
    check(cmdValid == 1'b0, "R4 no strobe", cmdValid, 0);
    sendCmd(8'hC5, 16'h0, 0, 0);
    check(cmdValid == 1'b0, "R6 ignored while locked", cmdValid, 0);
    check(doutOe == 1'b0, "R6 output released", doutOe, 0);
    readStatus(v);
    check(v[7:0] == 8'b10110000, "R4 parity flag", v[7:0], 8'b10110000);
    readStatus(v);
    check(v[7:0] == 8'b10100000, "R7 flags cleared", v[7:0], 8'b10100000);
  endtask

  task automatic t_unknownOp();
    logic [15:0] v;
    @(negedge clk) parityEn = 1'b0;
    startFrame();
    sendCmd(8'h11, 16'h0, 0, 0);
    check(cmdValid == 1'b0, "R5 no strobe", cmdValid, 0);
    sendCmd(8'hC6, 16'h0, 0, 0);
    check(doutOe == 1'b0 && cmdValid == 1'b0, "R6 locked ignores input", {doutOe, cmdValid}, 0);
    readStatus(v);
    check(v[7:0] == 8'b10101000, "R5 instruction flag", v[7:0], 8'b10101000);
  endtask

  task automatic t_busy();
    logic [15:0] v;
    @(negedge clk) busyIn = 1'b1;
    readStatus(v);
    check(v[7:0] == 8'b10100100, "R8 busy status", v[7:0], 8'b10100100);
    @(negedge clk) busyIn = 1'b0;
    readStatus(v);
    check(v[7:0] == 8'b10100000, "R8 idle status", v[7:0], 8'b10100000);
  endtask

  task automatic t_ptrRead();
    logic [15:0] v;
    @(negedge clk) begin ptrIn = 16'hA55A; parityEn = 1'b1; end
    startFrame();
    sendCmd(8'hC6, 16'h0, 0, 0);
    check(doutOe == 1'b1, "R9 pointer drives", doutOe, 1);
    readBits(16, v);
    check(v == 16'hA55A, "R9 pointer value", v, 16'hA55A);
    @(negedge clk) csIn = 1'b0;
    @(negedge clk);
    check(doutOe == 1'b0, "R9 release on cs low", doutOe, 0);
  endtask

  task automatic t_eraseExtra();
    @(negedge clk) parityEn = 1'b0;
    startFrame();
    sendCmd(8'h92, 16'h0, 0, 0);
    check(cmdValid && cmdOpcode == 8'h92 && cmdAddr == 16'h0, "R2 erase-all no address",
          {cmdOpcode, cmdAddr}, {8'h92, 16'h0});
    check(doutOe == 1'b0, "R9 erase-all hi-z", doutOe, 0);
    sendCmd(8'hC5, 16'h0, 0, 0);
    check(cmdValid == 1'b0 && doutOe == 1'b0, "R11 extra bits ignored", {doutOe, cmdValid}, 0);
  endtask

  task automatic t_abort();
    logic [15:0] v;
    @(negedge clk) parityEn = 1'b0;
    startFrame();
    sendBits(32'h15, 5);
    startFrame();
    sendCmd(8'hCB, 16'hBEEF, 1, 0);
    check(cmdValid && cmdAddr == 16'hBEEF, "R10 frame after abort", cmdAddr, 16'hBEEF);
    readStatus(v);
    check(v[7:0] == 8'b10100000, "R10 abort raised no error", v[7:0], 8'b10100000);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    t_reset();
    t_seqRead(0);
    t_seqRead(1);
    t_writeAt();
    t_parityErr();
    t_unknownOp();
    t_busy();
    t_ptrRead();
    t_eraseExtra();
    t_abort();
    @(negedge clk) csIn = 1'b0;
    repeat (2) @(negedge clk);
    finishRun();
  end

  initial begin
    repeat (50000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog: actual=running expected=done");
    finishRun();
  end

endmodule